// File: doc/BRIEF.md
# Nonvolatile Setting Store/Recall Controller

This block owns two wiper setting registers and a sixteen-byte array that models the nonvolatile store behind them. Slots 0 and 1 hold the saved values of wiper 0 and wiper 1. Slots 2 to 15 are free bytes for the user. A serial front end, which is not part of this block, hands over each frame already decoded into a 4-bit opcode, a 4-bit address and an 8-bit data byte. An arithmetic unit, also outside this block, sends new wiper values through a separate write port.

Saving to the store and recalling from it are slow. Each kind of operation lasts its own parameterised number of cycles. While an operation runs, the ready output is low, and any command or wiper write that arrives is discarded and recorded in a sticky flag. The block also handles three more sources of change:
- an active-low preset pin that parks both wipers at midscale and reloads them from the store when it is released;
- an active-low write-protect pin that freezes the wipers against ordinary writes;
- an automatic recall of both wipers after reset.

Read operations deliver one byte on a readback port, to be shifted out in the next frame.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, every store slot and both wipers hold midscale 0x80. Ready stays low for exactly RECALL_CYC cycles, during which both wipers are reloaded from slots 0 and 1.
- R2: Opcode 3 writes the data byte into the slot selected by the 4-bit address. Ready is low for exactly SAVE_CYC cycles.
- R3: Opcode 2 copies wiper N, where N is address bit 0, into slot N. Ready is low for exactly SAVE_CYC cycles.
- R4: Opcode 9 returns the addressed slot and opcode 10 returns wiper N (address bit 0). Each takes READ_CYC cycles of ready low. At the end, rb_data carries the byte and rb_vld pulses for one cycle, in the first cycle in which ready is high again.
- R5: Opcode 1 reloads wiper N from slot N on the next clock edge without lowering ready, and clears idle_lp. Opcode 0 sets idle_lp. idle_lp is 1 after reset.
- R6: Opcode 8 reloads both wipers from slots 0 and 1 after exactly RECALL_CYC cycles of ready low.
- R7: A command or wiper write that arrives while ready is low, or while preset_n is low, has no effect and sets dropped. dropped is 0 after reset and stays set until the next reset.
- R8: While preset_n is low, both wipers are held at 0x80 and ready is low, and any operation in progress is abandoned without writing the store. After preset_n rises, ready stays low for exactly PRESET_CYC cycles, and then both wipers are reloaded from slots 0 and 1.
- R9: While wprot_n is low, the wiper write port has no effect. Opcode 1, opcode 8 and preset still change the wipers.
- R10: With ready high, wprot_n high and no command in the same cycle, wr_en[i] loads wr_val_i into wiper i on the next clock edge.
- R11: Any opcode other than 0, 1, 2, 3, 8, 9 and 10 is accepted without lowering ready and changes nothing in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| cmd_valid | input | 1 | Decoded frame present this cycle |
| cmd_op | input | 4 | Decoded opcode |
| cmd_addr | input | 4 | Store slot or wiper select (bit 0) |
| cmd_data | input | 8 | Data byte of the frame |
| wr_en | input | 2 | Per-wiper write strobe from the arithmetic unit |
| wr_val0 | input | 8 | New value for wiper 0 |
| wr_val1 | input | 8 | New value for wiper 1 |
| preset_n | input | 1 | Hardware preset, active low |
| wprot_n | input | 1 | Write protect, active low |
| wiper0 | output | 8 | Wiper 0 setting |
| wiper1 | output | 8 | Wiper 1 setting |
| ready | output | 1 | High when no operation is running |
| rb_data | output | 8 | Byte for the next outgoing frame |
| rb_vld | output | 1 | One-cycle pulse when rb_data is refreshed |
| dropped | output | 1 | Sticky: an input was discarded |
| idle_lp | output | 1 | Low-power idle mode indicator |

## Verification
Directed sequences probe the boundaries:
- the length of each busy window, counted cycle by cycle, which separates the per-opcode durations from one another;
- commands that collide with a running save, which isolate the drop path;
- a preset that interrupts a save, which shows that an abandoned operation leaves the store untouched;
- write-protect held low while the ordinary write port, opcode 1 and opcode 8 are exercised, which separates the blocked path from the exempt ones.

A seeded random mix of opcodes, addresses, data and write-protect levels then runs against a bench model of the store and wipers. It distinguishes save from direct write, and slot readback from wiper readback, across all sixteen slots.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,    // power-on recall in progress
    ST_IDLE,    // accepting commands
    ST_BUSY,    // timed store/recall/read operation
    ST_HOLD,    // preset pin held low
    ST_RELOAD   // preset released, recall pending
  } nvs_state_e;

  localparam logic [3:0] OP_NOP        = 4'd0;
  localparam logic [3:0] OP_RECALL_ONE = 4'd1;
  localparam logic [3:0] OP_SAVE       = 4'd2;
  localparam logic [3:0] OP_PUT        = 4'd3;
  localparam logic [3:0] OP_RECALL_ALL = 4'd8;
  localparam logic [3:0] OP_GET        = 4'd9;
  localparam logic [3:0] OP_PEEK       = 4'd10;

  // midscale code for a given data width
  function automatic int unsigned mid_code(input int unsigned dw);
    return 1 << (dw - 1);
  endfunction

  // opcodes that run a timed operation and lower ready
  function automatic logic is_timed(input logic [3:0] op);
    return (op == OP_SAVE) || (op == OP_PUT) || (op == OP_RECALL_ALL) ||
           (op == OP_GET) || (op == OP_PEEK);
  endfunction

  // wiper index selected by an address field
  function automatic logic wiper_of(input logic [3:0] addr);
    return addr[0];
  endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CW   = 6,
  parameter int INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          zero
);
  localparam logic [CW-1:0] INIT_M1 = CW'(INIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= INIT_M1;
    else if (start)      cnt <= len - CW'(1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int MID = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] slot0,
  output logic [DW-1:0] slot1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[i] <= DW'(MID);
      else if (we && waddr == AW'(i))     mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign slot0 = mem[0];
  assign slot1 = mem[1];
endmodule

// File: rtl/nvs_wipers.sv
module nvs_wipers #(
  parameter int DW  = 8,
  parameter int MID = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_mid,
  input  logic               load_all,
  input  logic [1:0][DW-1:0] all_v,
  input  logic               load_one,
  input  logic               one_sel,
  input  logic [DW-1:0]      one_v,
  input  logic [1:0]         wr_en,
  input  logic [1:0][DW-1:0] wr_v,
  output logic [1:0][DW-1:0] w
);
  // priority: preset hold > recall of both > single recall > plain write
  for (genvar i = 0; i < 2; i++) begin : g_w
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              w[i] <= DW'(MID);
      else if (force_mid)                      w[i] <= DW'(MID);
      else if (load_all)                       w[i] <= all_v[i];
      else if (load_one && one_sel == 1'(i))   w[i] <= one_v;
      else if (wr_en[i])                       w[i] <= wr_v[i];
    end
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter int SAVE_CYC   = 40,
  parameter int RECALL_CYC = 12,
  parameter int READ_CYC   = 6,
  parameter int PRESET_CYC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [1:0]    wr_en,
  input  logic [DW-1:0] wr_val0,
  input  logic [DW-1:0] wr_val1,
  input  logic          preset_n,
  input  logic          wprot_n,
  output logic [DW-1:0] wiper0,
  output logic [DW-1:0] wiper1,
  output logic          ready,
  output logic [DW-1:0] rb_data,
  output logic          rb_vld,
  output logic          dropped,
  output logic          idle_lp
);
  localparam int MID  = int'(mid_code(DW));
  localparam int M1   = (SAVE_CYC > RECALL_CYC) ? SAVE_CYC : RECALL_CYC;
  localparam int M2   = (READ_CYC > PRESET_CYC) ? READ_CYC : PRESET_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [CW-1:0] op_len(input logic [3:0] op);
    if (op == OP_SAVE || op == OP_PUT) return CW'(SAVE_CYC);
    else if (op == OP_RECALL_ALL)      return CW'(RECALL_CYC);
    else                               return CW'(READ_CYC);
  endfunction

  nvs_state_e st;
  logic [3:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [1:0][DW-1:0] w;
  logic [DW-1:0] rdata, slot0, slot1;
  logic          t_zero, t_start;
  logic [CW-1:0] t_len;

  // named internal events
  logic idle_ok, ev_accept, ev_drop, ev_timed, ev_finish;
  logic ev_store_wr, ev_recall_all, ev_load_one;
  logic [1:0] wr_ok;
  logic [AW-1:0] st_waddr;
  logic [DW-1:0] st_wdata;

  assign idle_ok   = (st == ST_IDLE) && preset_n;
  assign ev_accept = cmd_valid && idle_ok;
  assign ev_drop   = (cmd_valid || (|wr_en)) && !idle_ok;
  assign ev_timed  = ev_accept && is_timed(cmd_op);
  assign ev_finish = preset_n && t_zero &&
                     (st == ST_BUSY || st == ST_BOOT || st == ST_RELOAD);

  assign ev_store_wr   = ev_finish && (st == ST_BUSY) &&
                         (op_q == OP_SAVE || op_q == OP_PUT);
  assign ev_recall_all = ev_finish &&
                         ((st != ST_BUSY) || (op_q == OP_RECALL_ALL));
  assign ev_load_one   = ev_accept && (cmd_op == OP_RECALL_ONE);
  assign wr_ok         = wr_en & {2{idle_ok && wprot_n && !cmd_valid}};

  assign st_waddr = (op_q == OP_SAVE) ? AW'(wiper_of(4'(addr_q))) : addr_q;
  assign st_wdata = (op_q == OP_SAVE) ? w[wiper_of(4'(addr_q))] : data_q;

  assign t_start = ev_timed || (st == ST_HOLD && preset_n);
  assign t_len   = ev_timed ? op_len(cmd_op) : CW'(PRESET_CYC);

  nvs_timer #(.CW(CW), .INIT(RECALL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .zero(t_zero)
  );

  nvs_store #(.DW(DW), .AW(AW), .MID(MID)) u_store (
    .clk(clk), .rst_n(rst_n), .we(ev_store_wr), .waddr(st_waddr),
    .wdata(st_wdata), .raddr(addr_q), .rdata(rdata),
    .slot0(slot0), .slot1(slot1)
  );

  nvs_wipers #(.DW(DW), .MID(MID)) u_wipers (
    .clk(clk), .rst_n(rst_n),
    .force_mid(!preset_n),
    .load_all(ev_recall_all), .all_v({slot1, slot0}),
    .load_one(ev_load_one), .one_sel(wiper_of(4'(cmd_addr))),
    .one_v(wiper_of(4'(cmd_addr)) ? slot1 : slot0),
    .wr_en(wr_ok), .wr_v({wr_val1, wr_val0}),
    .w(w)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_BOOT;
    end else if (!preset_n) begin
      st <= ST_HOLD;
    end else begin
      case (st)
        ST_BOOT, ST_BUSY, ST_RELOAD: if (t_zero) st <= ST_IDLE;
        ST_IDLE:                     if (ev_timed) st <= ST_BUSY;
        ST_HOLD:                     st <= ST_RELOAD;
        default:                     st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      addr_q <= '0;
      data_q <= '0;
    end else if (ev_timed) begin
      op_q   <= cmd_op;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  // readback byte for the next frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_data <= '0;
      rb_vld  <= 1'b0;
    end else if (ev_finish && st == ST_BUSY && op_q == OP_GET) begin
      rb_data <= rdata;
      rb_vld  <= 1'b1;
    end else if (ev_finish && st == ST_BUSY && op_q == OP_PEEK) begin
      rb_data <= w[wiper_of(4'(addr_q))];
      rb_vld  <= 1'b1;
    end else begin
      rb_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dropped <= 1'b0;
    else if (ev_drop) dropped <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   idle_lp <= 1'b1;
    else if (ev_accept && cmd_op == OP_NOP)       idle_lp <= 1'b1;
    else if (ev_load_one)                         idle_lp <= 1'b0;
  end

  assign ready  = (st == ST_IDLE);
  assign wiper0 = w[0];
  assign wiper1 = w[1];
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          preset_n,
  input logic          wprot_n,
  input logic          ready,
  input logic          dropped,
  input logic          rb_vld,
  input logic [DW-1:0] wiper0,
  input logic [DW-1:0] wiper1,
  input logic          ev_drop,
  input logic          ev_load_one,
  input logic          ev_recall_all
);
  localparam logic [DW-1:0] MIDV = DW'(1 << (DW - 1));

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> dropped); // R7

  AST_DROP_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> dropped); // R7

  AST_PRESET_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> (wiper0 == MIDV && wiper1 == MIDV && !ready)); // R8

  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wprot_n && preset_n && !ev_load_one && !ev_recall_all)
    |=> (wiper0 == $past(wiper0) && wiper1 == $past(wiper1))); // R9

  AST_RB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_vld |-> (ready && !$past(ready))); // R4

  AST_RECALL_ONE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ready && preset_n && cmd_op == 4'd1) |=> ready); // R5
endmodule

bind nvs_ctrl nvs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .preset_n(preset_n), .wprot_n(wprot_n), .ready(ready),
  .dropped(dropped), .rb_vld(rb_vld), .wiper0(wiper0), .wiper1(wiper1),
  .ev_drop(ev_drop), .ev_load_one(ev_load_one),
  .ev_recall_all(ev_recall_all)
);

// File: tb/sim_nvs_ctrl.sv
module sim_nvs_ctrl;
  localparam int SAVE_CYC   = 40;
  localparam int RECALL_CYC = 12;
  localparam int READ_CYC   = 6;
  localparam int PRESET_CYC = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cmd_valid, preset_n, wprot_n;
  logic [3:0] cmd_op, cmd_addr;
  logic [7:0] cmd_data, wr_val0, wr_val1;
  logic [1:0] wr_en;
  logic [7:0] wiper0, wiper1, rb_data;
  logic       ready, rb_vld, dropped, idle_lp;

  nvs_ctrl #(.DW(8), .AW(4), .SAVE_CYC(SAVE_CYC), .RECALL_CYC(RECALL_CYC),
             .READ_CYC(READ_CYC), .PRESET_CYC(PRESET_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_en(wr_en),
    .wr_val0(wr_val0), .wr_val1(wr_val1), .preset_n(preset_n),
    .wprot_n(wprot_n), .wiper0(wiper0), .wiper1(wiper1), .ready(ready),
    .rb_data(rb_data), .rb_vld(rb_vld), .dropped(dropped), .idle_lp(idle_lp)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_st [16];
  logic [7:0] m_w  [2];

  function automatic int exp_len(input logic [3:0] op);
    case (op)
      4'd2, 4'd3: return SAVE_CYC;
      4'd8:       return RECALL_CYC;
      4'd9, 4'd10: return READ_CYC;
      default:    return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_w(input string req);
    chk(wiper0 == m_w[0], req, wiper0, m_w[0]);
    chk(wiper1 == m_w[1], req, wiper1, m_w[1]);
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // issue, wait for ready, check busy length and readback
  task automatic send(input logic [3:0] op, input logic [3:0] a, input logic [7:0] d,
                      input string req, input logic [7:0] rb_exp);
    int n;
    issue(op, a, d);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp_len(op), req, n, exp_len(op));
    if (op == 4'd9 || op == 4'd10) begin
      chk(rb_vld == 1'b1, req, rb_vld, 1);
      chk(rb_data == rb_exp, req, rb_data, rb_exp);
    end
  endtask

  task automatic wport(input logic [1:0] en, input logic [7:0] v0, input logic [7:0] v1);
    @(negedge clk);
    wr_en = en; wr_val0 = v0; wr_val1 = v1;
    @(negedge clk);
    wr_en = 2'b00;
    if (wprot_n) begin
      if (en[0]) m_w[0] = v0;
      if (en[1]) m_w[1] = v1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd7411));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    wr_en = 0; wr_val0 = 0; wr_val1 = 0; preset_n = 1; wprot_n = 1;
    for (int i = 0; i < 16; i++) m_st[i] = 8'h80;
    m_w[0] = 8'h80; m_w[1] = 8'h80;
    repeat (3) @(negedge clk);

    // R1: power-on recall window
    rst_n = 1;
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == RECALL_CYC, "R1 boot busy", n, RECALL_CYC);
    chk_w("R1 wipers midscale");
    chk(dropped == 0, "R7 dropped after reset", dropped, 0);
    chk(idle_lp == 1, "R5 idle after reset", idle_lp, 1);
    send(4'd9, 4'd7, 8'h00, "R1 store midscale", 8'h80);

    // R2: direct store write, then read back
    send(4'd3, 4'd7, 8'h3C, "R2 put length", 8'h00); m_st[7] = 8'h3C;
    send(4'd9, 4'd7, 8'h00, "R2 put readback", 8'h3C);

    // R10: wiper write port
    wport(2'b11, 8'h11, 8'hE2);
    chk_w("R10 write port");

    // R3: save wiper 1, R4: read back slot and wiper
    send(4'd2, 4'd1, 8'h00, "R3 save length", 8'h00); m_st[1] = m_w[1];
    send(4'd9, 4'd1, 8'h00, "R3 save readback", 8'hE2);
    send(4'd10, 4'd0, 8'h00, "R4 wiper readback", 8'h11);

    // R5: single recall and idle flag
    wport(2'b10, 8'h00, 8'h05);
    send(4'd1, 4'd1, 8'h00, "R5 recall one no busy", 8'h00); m_w[1] = m_st[1];
    chk(ready == 1, "R5 ready high", ready, 1);
    chk_w("R5 recall one value");
    chk(idle_lp == 0, "R5 idle cleared", idle_lp, 0);
    send(4'd0, 4'd0, 8'h00, "R5 nop", 8'h00);
    chk(idle_lp == 1, "R5 idle set", idle_lp, 1);

    // R11: other opcode does nothing
    send(4'd14, 4'd1, 8'hFF, "R11 other opcode", 8'h00);
    chk(ready == 1, "R11 ready stays high", ready, 1);
    chk_w("R11 wipers unchanged");

    // R6: recall both
    wport(2'b11, 8'h77, 8'h66);
    send(4'd8, 4'd0, 8'h00, "R6 recall all length", 8'h00);
    m_w[0] = m_st[0]; m_w[1] = m_st[1];
    chk_w("R6 recall all values");

    // R7: collision with a running save
    issue(4'd3, 4'd9, 8'hAA); m_st[9] = 8'hAA;
    chk(dropped == 0, "R7 no drop yet", dropped, 0);
    issue(4'd9, 4'd2, 8'h00);
    wport(2'b01, 8'h99, 8'h00); m_w[0] = m_st[0];
    chk(dropped == 1, "R7 dropped set", dropped, 1);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    @(negedge clk);
    chk(ready == 1 && rb_vld == 0, "R7 dropped read not run", {ready, rb_vld}, 2);
    chk_w("R7 dropped write ignored");
    send(4'd9, 4'd9, 8'h00, "R7 save survived", 8'hAA);
    chk(dropped == 1, "R7 dropped sticky", dropped, 1);

    // R9: write protect
    wport(2'b01, 8'h33, 8'h00);
    wprot_n = 0;
    wport(2'b11, 8'h01, 8'h02);
    chk_w("R9 write blocked");
    send(4'd1, 4'd0, 8'h00, "R9 recall one under protect", 8'h00); m_w[0] = m_st[0];
    chk_w("R9 recall one value");
    send(4'd8, 4'd0, 8'h00, "R9 recall all under protect", 8'h00);
    m_w[0] = m_st[0]; m_w[1] = m_st[1];
    chk_w("R9 recall all value");
    wprot_n = 1;

    // R8: preset hold and reload
    wport(2'b11, 8'h44, 8'h55);
    @(negedge clk); preset_n = 0;
    @(negedge clk);
    chk(wiper0 == 8'h80 && wiper1 == 8'h80, "R8 preset midscale", {wiper0, wiper1}, 16'h8080);
    chk(ready == 0, "R8 ready low in preset", ready, 0);
    repeat (3) @(negedge clk);
    preset_n = 1;
    @(negedge clk);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == PRESET_CYC, "R8 reload length", n, PRESET_CYC);
    m_w[0] = m_st[0]; m_w[1] = m_st[1];
    chk_w("R8 reload values");

    // R8: preset aborts a save
    issue(4'd3, 4'd12, 8'h5A);
    repeat (5) @(negedge clk);
    preset_n = 0;
    repeat (2) @(negedge clk);
    preset_n = 1;
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    send(4'd9, 4'd12, 8'h00, "R8 aborted save", m_st[12]);

    // random mix against the model
    for (int it = 0; it < 120; it++) begin
      int k;
      logic [3:0] a;
      logic [7:0] d;
      k = $urandom % 8;
      a = 4'($urandom);
      d = 8'($urandom);
      wprot_n = (($urandom % 4) != 0);
      case (k)
        0: send(4'd0, a, d, "R5 rnd nop", 8'h00);
        1: begin send(4'd1, a, d, "R5 rnd recall one", 8'h00); m_w[a[0]] = m_st[a[0]]; end
        2: begin send(4'd2, a, d, "R3 rnd save", 8'h00); m_st[a[0]] = m_w[a[0]]; end
        3: begin send(4'd3, a, d, "R2 rnd put", 8'h00); m_st[a] = d; end
        4: begin send(4'd8, a, d, "R6 rnd recall all", 8'h00);
                 m_w[0] = m_st[0]; m_w[1] = m_st[1]; end
        5: send(4'd9, a, d, "R4 rnd get", m_st[a]);
        6: send(4'd10, a, d, "R4 rnd peek", m_w[a[0]]);
        default: wport(2'($urandom), d, ~d);
      endcase
      chk_w(wprot_n ? "R10 rnd wipers" : "R9 rnd wipers");
    end
    wprot_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule